// File: doc/BRIEF.md
# Message Bus Target Receiver

This block is the receive side of a target on a shared 32-bit synchronous message bus that links a central switching engine to its port controllers. An initiator holds an active-low envelope low for the whole of one message. The first word sampled with the initiator ready is a header. The block decodes that header and decides whether this target is one of the recipients.

When the block is addressed, it passes each later word that the initiator marks ready to a local word stream. The first payload word carries a start marker. Frame data messages end with a receive status word, which an active-low end-of-frame strobe marks in the same cycle. The block copies that word into a held status register and tags it as the end of the stream. Every message that was taken ends with a one-cycle completion pulse that carries a result code.

If the local receive buffer is full at the moment a word would be taken, the block cancels its reception. It drives the abort line low until the envelope closes and drops the rest of that message. The block assumes the bus is idle (envelope high) when reset is released. The envelope is high for at least one cycle between messages.

Top module: `msgbus_rx`

## Requirements
- R1: While reset is low, and in the cycle after it is released, out_valid, out_sop, out_eop and done_valid are 0, out_word, stat_word and done_code are 0, and abort_n is 1.
- R2: A word is taken on a rising clock edge only when env_n is 0 and irdy is 1. The first word taken after env_n goes low is the header. The message is for this target when header bits [31:24] are 0x01 (frame) or 0x02 (command) and bit PORT_SEL (default 3) of header bits [7:0] is 1. The header itself never appears on the word stream.
- R3: Each payload word taken in an addressed message appears on out_word with out_valid high in the cycle after the edge that took it. out_sop is high only with the first payload word.
- R4: In a cycle with irdy low, no word is taken, and buf_full has no effect.
- R5: In a frame message, a word taken with eof_n at 0 is output with out_eop high. It is copied into stat_word, and done_valid pulses with done_code 2'b00 (ok). Later words of that message are ignored.
- R6: In a command message, eof_n is ignored. When env_n returns high, done_valid pulses with done_code 2'b00.
- R7: A message that is not addressed (wrong bitmap bit or an unknown type) produces no output and no completion pulse before env_n returns high.
- R8: If buf_full is 1 when a payload word would be taken, that word is dropped. abort_n goes low in the next cycle, and done_valid pulses with done_code 2'b10. abort_n stays low while env_n is 0, no further words are output, and abort_n returns to 1 in the cycle after env_n is sampled high.
- R9: If env_n returns high in an addressed frame message before the end-of-frame word, done_valid pulses with done_code 2'b01 (truncated).
- R10: After a single idle cycle with env_n high, a new header is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 32 | Bus data word |
| env_n | input | 1 | Active-low message envelope |
| irdy | input | 1 | Initiator ready; capture enable |
| eof_n | input | 1 | Active-low end-of-frame, marks the status word |
| buf_full | input | 1 | Local receive buffer cannot take a word |
| abort_n | output | 1 | Active-low abort of the current reception |
| out_valid | output | 1 | out_word holds a new payload word |
| out_sop | output | 1 | First payload word of a message |
| out_eop | output | 1 | Word is the frame status word |
| out_word | output | 32 | Payload word |
| stat_word | output | 32 | Last captured frame status word (held) |
| done_valid | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 00 ok, 01 truncated, 10 aborted |

## Verification
Each fault in the receive state shows at the ports within one cycle of the next bus word. A target that stays in a drop state loses the start-marked word right after its next header. A target that misses the drop after end-of-frame puts an extra word on the stream in the cycle after the status word. An abort state that is lost or released early lifts abort_n, or emits a word, while the envelope is still low. A wrong frame/command flag shows as a done_code of the wrong type at the close of the envelope.

// File: rtl/msgbus_rx_pkg.sv
package msgbus_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a header
        ST_RECV  = 2'd1,   // addressed, taking payload
        ST_SKIP  = 2'd2,   // not addressed or frame finished
        ST_ABORT = 2'd3    // reception cancelled
    } rx_state_e;

    typedef enum logic [1:0] {
        END_OK    = 2'b00,
        END_TRUNC = 2'b01,
        END_ABORT = 2'b10
    } end_code_e;

    localparam int KIND_W = 8;
    localparam logic [KIND_W-1:0] KIND_FRAME = 8'h01;
    localparam logic [KIND_W-1:0] KIND_CMD   = 8'h02;

endpackage

// File: rtl/msgbus_rx_hdr.sv
module msgbus_rx_hdr
    import msgbus_rx_pkg::*;
#(
    parameter int MAP_W    = 8,
    parameter int PORT_SEL = 3
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [MAP_W-1:0]  dest_map,
    output logic              hit,
    output logic              is_frame
);
    logic known;

    always_comb begin
        is_frame = (kind == KIND_FRAME);
        known    = is_frame || (kind == KIND_CMD);
        hit      = known && dest_map[PORT_SEL];
    end

endmodule

// File: rtl/msgbus_rx_fsm.sv
module msgbus_rx_fsm
    import msgbus_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      env_n,
    input  logic      irdy,
    input  logic      eof_n,
    input  logic      buf_full,
    input  logic      hdr_hit,
    input  logic      hdr_frame,
    output rx_state_e nxt,
    output logic      ev_word,
    output logic      ev_first,
    output logic      ev_last,
    output logic      ev_close,
    output logic      ev_abort,
    output end_code_e close_code
);
    rx_state_e state_q;
    logic      frame_q;
    logic      first_q;
    logic      ev_hdr;
    logic      take;

    always_comb begin
        nxt      = state_q;
        ev_hdr   = 1'b0;
        ev_word  = 1'b0;
        ev_last  = 1'b0;
        ev_close = 1'b0;
        ev_abort = 1'b0;
        take     = !env_n && irdy;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    if (hdr_hit) begin
                        nxt    = ST_RECV;
                        ev_hdr = 1'b1;
                    end else begin
                        nxt = ST_SKIP;
                    end
                end
            end
            ST_RECV: begin
                if (env_n) begin
                    nxt      = ST_IDLE;
                    ev_close = 1'b1;
                end else if (irdy) begin
                    if (buf_full) begin
                        nxt      = ST_ABORT;
                        ev_abort = 1'b1;
                    end else begin
                        ev_word = 1'b1;
                        if (frame_q && !eof_n) begin
                            ev_last = 1'b1;
                            nxt     = ST_SKIP;
                        end
                    end
                end
            end
            ST_SKIP, ST_ABORT: begin
                if (env_n) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        ev_first   = ev_word && first_q;
        close_code = frame_q ? END_TRUNC : END_OK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frame_q <= 1'b0;
            first_q <= 1'b0;
        end else begin
            state_q <= nxt;
            if (ev_hdr) begin
                frame_q <= hdr_frame;
                first_q <= 1'b1;
            end else if (ev_word) begin
                first_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/msgbus_rx_out.sv
module msgbus_rx_out
    import msgbus_rx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  rx_state_e         nxt,
    input  logic              ev_word,
    input  logic              ev_first,
    input  logic              ev_last,
    input  logic              ev_close,
    input  logic              ev_abort,
    input  end_code_e         close_code,
    output logic              abort_n,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_word,
    output logic [DATA_W-1:0] stat_word,
    output logic              done_valid,
    output logic [1:0]        done_code
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_n    <= 1'b1;
            out_valid  <= 1'b0;
            out_sop    <= 1'b0;
            out_eop    <= 1'b0;
            out_word   <= '0;
            stat_word  <= '0;
            done_valid <= 1'b0;
            done_code  <= END_OK;
        end else begin
            abort_n    <= (nxt != ST_ABORT);
            out_valid  <= ev_word;
            out_sop    <= ev_first;
            out_eop    <= ev_last;
            done_valid <= ev_last || ev_close || ev_abort;
            if (ev_word) out_word  <= bus_data;
            if (ev_last) stat_word <= bus_data;
            if (ev_abort)      done_code <= END_ABORT;
            else if (ev_close) done_code <= close_code;
            else if (ev_last)  done_code <= END_OK;
        end
    end

endmodule

// File: rtl/msgbus_rx.sv
module msgbus_rx
    import msgbus_rx_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MAP_W    = 8,
    parameter int PORT_SEL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              env_n,
    input  logic              irdy,
    input  logic              eof_n,
    input  logic              buf_full,
    output logic              abort_n,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_word,
    output logic [DATA_W-1:0] stat_word,
    output logic              done_valid,
    output logic [1:0]        done_code
);
    localparam int KIND_LSB = DATA_W - KIND_W;

    logic      hdr_hit, hdr_frame;
    rx_state_e nxt;
    logic      ev_word, ev_first, ev_last, ev_close, ev_abort;
    end_code_e close_code;

    msgbus_rx_hdr #(.MAP_W(MAP_W), .PORT_SEL(PORT_SEL)) u_hdr (
        .kind     (bus_data[DATA_W-1:KIND_LSB]),
        .dest_map (bus_data[MAP_W-1:0]),
        .hit      (hdr_hit),
        .is_frame (hdr_frame)
    );

    msgbus_rx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .env_n      (env_n),
        .irdy       (irdy),
        .eof_n      (eof_n),
        .buf_full   (buf_full),
        .hdr_hit    (hdr_hit),
        .hdr_frame  (hdr_frame),
        .nxt        (nxt),
        .ev_word    (ev_word),
        .ev_first   (ev_first),
        .ev_last    (ev_last),
        .ev_close   (ev_close),
        .ev_abort   (ev_abort),
        .close_code (close_code)
    );

    msgbus_rx_out #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_data   (bus_data),
        .nxt        (nxt),
        .ev_word    (ev_word),
        .ev_first   (ev_first),
        .ev_last    (ev_last),
        .ev_close   (ev_close),
        .ev_abort   (ev_abort),
        .close_code (close_code),
        .abort_n    (abort_n),
        .out_valid  (out_valid),
        .out_sop    (out_sop),
        .out_eop    (out_eop),
        .out_word   (out_word),
        .stat_word  (stat_word),
        .done_valid (done_valid),
        .done_code  (done_code)
    );

endmodule

// File: rtl/msgbus_rx_chk.sv
module msgbus_rx_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_data,
    input logic              env_n,
    input logic              irdy,
    input logic              abort_n,
    input logic              out_valid,
    input logic              out_sop,
    input logic              out_eop,
    input logic [DATA_W-1:0] out_word,
    input logic [DATA_W-1:0] stat_word,
    input logic              done_valid,
    input logic [1:0]        done_code
);
    a_r3_word_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(!env_n && irdy) && out_word == $past(bus_data)));

    a_r3_sop_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    a_r5_eop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> (out_valid && done_valid && done_code == 2'b00 && stat_word == out_word));

    a_r8_silent_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |-> !out_valid);

    a_r8_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_n && !env_n) |=> !abort_n);

    a_r8_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_n && env_n) |=> abort_n);

    a_r8_abort_reported: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(abort_n) |-> (done_valid && done_code == 2'b10));

endmodule

bind msgbus_rx msgbus_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_data   (bus_data),
    .env_n      (env_n),
    .irdy       (irdy),
    .abort_n    (abort_n),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_word   (out_word),
    .stat_word  (stat_word),
    .done_valid (done_valid),
    .done_code  (done_code)
);

// File: tb/tb_msgbus_rx.sv
module tb_msgbus_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_data = '0;
    logic        env_n = 1'b1, irdy = 1'b0, eof_n = 1'b1, buf_full = 1'b0;
    logic        abort_n, out_valid, out_sop, out_eop, done_valid;
    logic [31:0] out_word, stat_word;
    logic [1:0]  done_code;

    int n_chk = 0, n_fail = 0;
    bit mon_en = 1'b0;
    int seen_ok = 0, seen_abort = 0;
    logic [31:0] ref_q[$];

    always #2 clk = ~clk;

    msgbus_rx dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic env; logic rdy; logic eof; logic full;
        logic [31:0] d;
        logic v; logic sop; logic eop; logic dv; logic [1:0] code; logic ab;
        logic [3:0] req;
    } row_t;

    // Headers: frame 0x01000008, command 0x02000008 (bit 3 set)
    localparam row_t TBL [29] = '{
        '{1,0,1,0,32'h0,          0,0,0,0,2'd0,1, 4'd2},  // R2 idle
        '{0,1,1,0,32'h0100_0008,  0,0,0,0,2'd0,1, 4'd2},  // R2 frame header hidden
        '{0,1,1,0,32'hA1A1_0001,  1,1,0,0,2'd0,1, 4'd3},  // R3 first word
        '{0,0,1,0,32'hDEAD_BEEF,  0,0,0,0,2'd0,1, 4'd4},  // R4 wait
        '{0,1,1,0,32'hB2B2_0002,  1,0,0,0,2'd0,1, 4'd3},  // R3 second word
        '{0,1,0,0,32'h5A5A_0003,  1,0,1,1,2'd0,1, 4'd5},  // R5 status word
        '{0,1,1,0,32'h7777_7777,  0,0,0,0,2'd0,1, 4'd5},  // R5 trailing ignored
        '{1,0,1,0,32'h0,          0,0,0,0,2'd0,1, 4'd5},
        '{0,1,1,0,32'h0200_0008,  0,0,0,0,2'd0,1, 4'd6},  // R6 command header
        '{0,1,0,0,32'hC1C1_0004,  1,1,0,0,2'd0,1, 4'd6},  // R6 eof ignored
        '{1,0,1,0,32'h0,          0,0,0,1,2'd0,1, 4'd6},  // R6 close ok
        '{0,1,1,0,32'h0100_0004,  0,0,0,0,2'd0,1, 4'd7},  // R7 other target
        '{0,1,0,0,32'hE0E0_0005,  0,0,0,0,2'd0,1, 4'd7},
        '{1,0,1,0,32'h0,          0,0,0,0,2'd0,1, 4'd7},
        '{0,1,1,0,32'h0300_0008,  0,0,0,0,2'd0,1, 4'd7},  // R7 unknown type
        '{0,1,1,0,32'hE1E1_0006,  0,0,0,0,2'd0,1, 4'd7},
        '{1,1,1,0,32'h0,          0,0,0,0,2'd0,1, 4'd7},
        '{0,1,1,0,32'h0100_0008,  0,0,0,0,2'd0,1, 4'd2},
        '{0,1,1,0,32'hD1D1_0007,  1,1,0,0,2'd0,1, 4'd3},
        '{0,0,1,1,32'hD2D2_0008,  0,0,0,0,2'd0,1, 4'd4},  // R4 full during wait
        '{0,1,1,1,32'hD3D3_0009,  0,0,0,1,2'd2,0, 4'd8},  // R8 abort
        '{0,1,1,0,32'hD4D4_000A,  0,0,0,0,2'd0,0, 4'd8},  // R8 held, dropped
        '{0,1,0,0,32'hD5D5_000B,  0,0,0,0,2'd0,0, 4'd8},
        '{1,0,1,0,32'h0,          0,0,0,0,2'd0,1, 4'd8},  // R8 release
        '{0,1,1,0,32'h0100_0008,  0,0,0,0,2'd0,1, 4'd2},
        '{0,1,1,0,32'hF1F1_000C,  1,1,0,0,2'd0,1, 4'd3},
        '{1,0,1,0,32'h0,          0,0,0,1,2'd1,1, 4'd9},  // R9 truncated
        '{0,1,1,0,32'h0100_0008,  0,0,0,0,2'd0,1, 4'd10}, // R10 back to back
        '{0,1,0,0,32'hF2F2_000D,  1,1,1,1,2'd0,1, 4'd10}
    };

    task automatic drive(input logic e, input logic r, input logic f, input logic full, input logic [31:0] d);
        @(negedge clk);
        env_n = e; irdy = r; eof_n = f; buf_full = full; bus_data = d;
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (out_valid) begin
                if (ref_q.size() == 0)
                    chk(1'b0, "R3 unexpected word", {32'h0, out_word}, 64'h0);
                else begin
                    logic [31:0] e;
                    e = ref_q.pop_front();
                    chk(out_word == e, "R3 stream word", {32'h0, out_word}, {32'h0, e});
                end
                if (out_eop) chk(stat_word == out_word, "R5 status copy", {32'h0, stat_word}, {32'h0, out_word});
            end
            if (done_valid && done_code == 2'b00) seen_ok++;
            if (done_valid && done_code == 2'b10) seen_abort++;
        end
    end

    task automatic send_frame(input bit hit, input int nw, input int abort_at,
                              inout int exp_ok, inout int exp_ab);
        bit ab = 1'b0;
        drive(0, 1, 1, 0, hit ? 32'h0100_0008 : 32'h0100_0010);
        for (int i = 0; i < nw; i++) begin
            logic [31:0] w = $urandom;
            while ($urandom % 3 == 0) drive(0, 0, 1, $urandom % 2, $urandom);
            if (i == abort_at) begin
                drive(0, 1, (i == nw-1) ? 1'b0 : 1'b1, 1, w);
                ab = 1'b1;
            end else begin
                drive(0, 1, (i == nw-1) ? 1'b0 : 1'b1, 0, w);
                if (hit && !ab) ref_q.push_back(w);
            end
        end
        drive(1, 0, 1, 0, 32'h0);
        if (hit) begin
            if (ab) exp_ab++; else exp_ok++;
        end
    endtask

    initial begin
        #(4 * 20000);
        chk(1'b0, "watchdog", 64'h0, 64'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int exp_ok = 0, exp_ab = 0;
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk({out_valid, out_sop, out_eop, done_valid, abort_n} == 5'b00001 && out_word == 0 && stat_word == 0 && done_code == 0,
            "R1 reset outputs", {59'h0, out_valid, out_sop, out_eop, done_valid, abort_n}, 64'h1);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk({out_valid, done_valid, abort_n} == 3'b001, "R1 after release", {61'h0, out_valid, done_valid, abort_n}, 64'h1);

        // Vector table walk
        for (int i = 0; i < 29; i++) begin
            @(negedge clk);
            env_n = TBL[i].env; irdy = TBL[i].rdy; eof_n = TBL[i].eof;
            buf_full = TBL[i].full; bus_data = TBL[i].d;
            @(posedge clk); #1;
            begin
                logic [6:0] act, exp;
                string tag;
                act = {out_valid, out_sop, out_eop, done_valid, (done_valid ? done_code : 2'b00), abort_n};
                exp = {TBL[i].v, TBL[i].sop, TBL[i].eop, TBL[i].dv, TBL[i].code, TBL[i].ab};
                tag = $sformatf("R%0d row %0d", TBL[i].req, i);
                chk(act == exp && (!TBL[i].v || out_word == TBL[i].d), tag,
                    {25'h0, act, out_word}, {25'h0, exp, TBL[i].d});
            end
        end
        @(posedge clk); #1;
        chk(stat_word == 32'hF2F2_000D, "R5 status held", {32'h0, stat_word}, 64'hF2F2_000D);

        // R1 reset in mid-message
        drive(1, 0, 1, 0, 0);
        drive(0, 1, 1, 0, 32'h0100_0008);
        drive(0, 1, 1, 1, 32'h1);
        @(negedge clk) rst_n = 1'b0; env_n = 1'b1; buf_full = 1'b0;
        @(posedge clk); #1;
        chk(abort_n && !out_valid && !done_valid, "R1 mid reset", {61'h0, abort_n, out_valid, done_valid}, 64'h4);
        @(negedge clk) rst_n = 1'b1;

        // Random frames with wait states, foreign targets and aborts
        drive(1, 0, 1, 0, 0);
        mon_en = 1'b1;
        for (int m = 0; m < 40; m++) begin
            int nw = 1 + $urandom % 6;
            bit hit = ($urandom % 4) != 0;
            int abort_at = ($urandom % 4 == 0) ? int'($urandom % nw) : -1;
            send_frame(hit, nw, abort_at, exp_ok, exp_ab);
        end
        repeat (3) drive(1, 0, 1, 0, 0);
        mon_en = 1'b0;
        chk(ref_q.size() == 0, "R3 queue drained", ref_q.size(), 64'h0);
        chk(seen_ok == exp_ok, "R5 ok completions", seen_ok, exp_ok);
        chk(seen_abort == exp_ab, "R8 abort completions", seen_abort, exp_ab);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule